// File: doc/BRIEF.md
# Transmit Ring Slot Pointer Controller

This block steers frames from a gateway into a ring of message-object slots that together form a transmit FIFO. A single receive object on the source side forwards each frame. The frame is written into the slot that the current pointer selects. Several destination slots thus share one feed. Software programs three slot indices: the lowest slot of the ring, the highest slot, and a watermark slot. After each stored frame, one post-processing cycle moves the pointer to the next slot. The pointer wraps from the highest slot back to the lowest.

The watermark request fires when the pointer lands on the watermark slot. It does not wait for the ring to be full. It travels on the base object's receive interrupt line, which also carries ordinary receive-OK requests. Two sticky cause bits tell software which source raised a given pulse. Transmit-OK events for individual slots raise their own request line. A lost-message flag records that an unread slot was overwritten. That flag never raises an interrupt.

Top module: `fifo_ring_ptr`

## Requirements
- R1: After reset the pointer is 0, the ring spans slots 0 to SLOTS-1 with the watermark at SLOTS-1, and all new-data bits, interrupt outputs, cause bits and the lost flag are 0.
- R2: An accepted frameStored strobe sets bit curIdx of newDataVec at the next edge. At the edge after that (post-processing), curIdx moves to curIdx+1. If curIdx equalled the top index, it moves to the bottom index instead.
- R3: A frameStored strobe that arrives in the cycle right after an accepted strobe, while post-processing is pending, is ignored. It neither stores nor advances the pointer.
- R4: The shared receive line rxIrq pulses for exactly one cycle at the post-processing edge when rxIntEn is 1, or when ovfIntEn is 1 and the updated pointer equals the watermark index. Otherwise it stays 0.
- R5: Sticky bit causeRx records a receive-enable pulse and sticky bit causeOvf records a watermark hit. Writing 1 on causeClr bit 0 clears causeRx, and writing 1 on causeClr bit 1 clears causeOvf. A new event in the same cycle wins over the clear.
- R6: A cycle with cfgWrEn=1 loads the bottom, top and watermark indices and reloads curIdx to the new bottom at that edge. It also cancels any pending post-processing and any frameStored in the same cycle.
- R7: Storing into a slot whose new-data bit is already 1 sets lostMsg. The flag stays set until a lostClr pulse clears it, and it never drives rxIrq or txIrq.
- R8: A frameSent strobe clears bit sentIdx of newDataVec. If txIntEn is 1, it also raises txIrq for one cycle at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Load ring configuration |
| cfgBottom | input | IDXW | Lowest slot of the ring |
| cfgTop | input | IDXW | Highest slot of the ring |
| cfgSelect | input | IDXW | Watermark slot |
| rxIntEn | input | 1 | Receive-OK interrupt enable of the base object |
| ovfIntEn | input | 1 | Watermark interrupt enable |
| txIntEn | input | 1 | Transmit-OK interrupt enable |
| frameStored | input | 1 | Frame written into slot curIdx |
| frameSent | input | 1 | Slot sentIdx transmitted |
| sentIdx | input | IDXW | Slot that was transmitted |
| lostClr | input | 1 | Clear lost-message flag |
| causeClr | input | 2 | Clear cause bits (bit0 rx, bit1 watermark) |
| curIdx | output | IDXW | Current slot pointer |
| rxIrq | output | 1 | Shared receive/watermark request pulse |
| txIrq | output | 1 | Transmit-OK request pulse |
| causeRx | output | 1 | Sticky receive cause |
| causeOvf | output | 1 | Sticky watermark cause |
| lostMsg | output | 1 | Lost-message flag |
| newDataVec | output | SLOTS | Per-slot new-data bits |

## Verification
The bench walks the pointer through the top-to-bottom wrap. A design that advanced past the top slot, or returned to slot 0 instead of the programmed bottom, would report the wrong index. It separates the two sources of the shared line. A design that tied the watermark to a full ring, or let the lost flag raise a request, would pulse at the wrong time or set the wrong cause bit. It also sends a strobe during post-processing and a configuration write that cancels a pending advance. A design without those guards would skip a slot or move the pointer away from the reloaded bottom.

// File: rtl/fifo_slot_pkg.sv
package fifo_slot_pkg;
  typedef struct packed {
    logic store;    // accept frame into current slot
    logic advance;  // post-processing: move pointer
    logic rxReq;    // receive-enable request on shared line
    logic ovfReq;   // watermark request on shared line
    logic txReq;    // transmit-OK request
  } ctrlStrobes_t;
endpackage

// File: rtl/fifo_slot_ctrl.sv
module fifo_slot_ctrl
  import fifo_slot_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWrEn,
  input  logic         frameStored,
  input  logic         frameSent,
  input  logic         rxIntEn,
  input  logic         ovfIntEn,
  input  logic         txIntEn,
  input  logic         ovfHit,
  output ctrlStrobes_t strobes
);
  logic ppPending;

  always_comb begin
    strobes.store   = frameStored && !ppPending && !cfgWrEn;
    strobes.advance = ppPending && !cfgWrEn;
    strobes.rxReq   = strobes.advance && rxIntEn;
    strobes.ovfReq  = strobes.advance && ovfIntEn && ovfHit;
    strobes.txReq   = frameSent && txIntEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ppPending <= 1'b0;
    else       ppPending <= strobes.store;
  end
endmodule

// File: rtl/fifo_slot_dp.sv
module fifo_slot_dp
  import fifo_slot_pkg::*;
#(
  parameter int SLOTS = 16,
  localparam int IDXW = $clog2(SLOTS)
)(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic             cfgWrEn,
  input  logic [IDXW-1:0]  cfgBottom,
  input  logic [IDXW-1:0]  cfgTop,
  input  logic [IDXW-1:0]  cfgSelect,
  input  logic             frameSent,
  input  logic [IDXW-1:0]  sentIdx,
  input  logic             lostClr,
  input  logic [1:0]       causeClr,
  output logic             ovfHit,
  output logic [IDXW-1:0]  curIdx,
  output logic             rxIrq,
  output logic             txIrq,
  output logic             causeRx,
  output logic             causeOvf,
  output logic             lostMsg,
  output logic [SLOTS-1:0] newDataVec
);
  logic [IDXW-1:0]  botIdx, topIdx, selIdx, nextIdx;
  logic [SLOTS-1:0] setMask, clrMask;

  always_comb begin
    nextIdx = (curIdx == topIdx) ? botIdx : IDXW'(curIdx + 1'b1);
    ovfHit  = (nextIdx == selIdx);
    setMask = strobes.store ? (SLOTS'(1) << curIdx) : '0;
    clrMask = frameSent ? (SLOTS'(1) << sentIdx) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      botIdx <= '0;
      topIdx <= IDXW'(SLOTS - 1);
      selIdx <= IDXW'(SLOTS - 1);
      curIdx <= '0;
    end else if (cfgWrEn) begin
      botIdx <= cfgBottom;
      topIdx <= cfgTop;
      selIdx <= cfgSelect;
      curIdx <= cfgBottom;
    end else if (strobes.advance) begin
      curIdx <= nextIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newDataVec <= '0;
      lostMsg    <= 1'b0;
      rxIrq      <= 1'b0;
      txIrq      <= 1'b0;
      causeRx    <= 1'b0;
      causeOvf   <= 1'b0;
    end else begin
      newDataVec <= (newDataVec & ~clrMask) | setMask;
      if (strobes.store && newDataVec[curIdx]) lostMsg <= 1'b1;
      else if (lostClr)                        lostMsg <= 1'b0;
      rxIrq <= strobes.rxReq || strobes.ovfReq;
      txIrq <= strobes.txReq;
      if (strobes.rxReq)    causeRx <= 1'b1;
      else if (causeClr[0]) causeRx <= 1'b0;
      if (strobes.ovfReq)   causeOvf <= 1'b1;
      else if (causeClr[1]) causeOvf <= 1'b0;
    end
  end
endmodule

// File: rtl/fifo_ring_ptr.sv
module fifo_ring_ptr
  import fifo_slot_pkg::*;
#(
  parameter int SLOTS = 16,
  localparam int IDXW = $clog2(SLOTS)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [IDXW-1:0]  cfgBottom,
  input  logic [IDXW-1:0]  cfgTop,
  input  logic [IDXW-1:0]  cfgSelect,
  input  logic             rxIntEn,
  input  logic             ovfIntEn,
  input  logic             txIntEn,
  input  logic             frameStored,
  input  logic             frameSent,
  input  logic [IDXW-1:0]  sentIdx,
  input  logic             lostClr,
  input  logic [1:0]       causeClr,
  output logic [IDXW-1:0]  curIdx,
  output logic             rxIrq,
  output logic             txIrq,
  output logic             causeRx,
  output logic             causeOvf,
  output logic             lostMsg,
  output logic [SLOTS-1:0] newDataVec
);
  ctrlStrobes_t strobes;
  logic         ovfHit;

  fifo_slot_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .frameStored(frameStored),
    .frameSent(frameSent), .rxIntEn(rxIntEn), .ovfIntEn(ovfIntEn),
    .txIntEn(txIntEn), .ovfHit(ovfHit), .strobes(strobes)
  );

  fifo_slot_dp #(.SLOTS(SLOTS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgWrEn(cfgWrEn),
    .cfgBottom(cfgBottom), .cfgTop(cfgTop), .cfgSelect(cfgSelect),
    .frameSent(frameSent), .sentIdx(sentIdx), .lostClr(lostClr),
    .causeClr(causeClr), .ovfHit(ovfHit), .curIdx(curIdx), .rxIrq(rxIrq),
    .txIrq(txIrq), .causeRx(causeRx), .causeOvf(causeOvf),
    .lostMsg(lostMsg), .newDataVec(newDataVec)
  );
endmodule

// File: rtl/fifo_ring_ptr_chk.sv
module fifo_ring_ptr_chk #(
  parameter int SLOTS = 16,
  localparam int IDXW = $clog2(SLOTS)
)(
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrEn,
  input logic [IDXW-1:0]  cfgBottom,
  input logic             frameStored,
  input logic             frameSent,
  input logic             txIntEn,
  input logic             lostClr,
  input logic [IDXW-1:0]  curIdx,
  input logic             rxIrq,
  input logic             txIrq,
  input logic             causeRx,
  input logic             causeOvf,
  input logic             lostMsg
);
  // R2: pointer moves only two edges after a strobe or right after a config write
  a_r2_ptr_source: assert property (@(posedge clk) disable iff (!rstN)
    (curIdx != $past(curIdx)) |-> ($past(cfgWrEn) || $past(frameStored, 2)));

  // R4: shared line is a single-cycle pulse
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);

  // R5: every pulse leaves a recorded cause
  a_r5_cause_recorded: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> (causeRx || causeOvf));

  // R6: config write reloads the pointer to the new bottom
  a_r6_cfg_reload: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWrEn) |-> (curIdx == $past(cfgBottom)));

  // R7: lost flag holds until cleared
  a_r7_lost_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lostMsg) && !$past(lostClr)) |-> lostMsg);

  // R8: transmit request only after an enabled send
  a_r8_tx_source: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> $past(frameSent && txIntEn));
endmodule

bind fifo_ring_ptr fifo_ring_ptr_chk #(.SLOTS(SLOTS)) u_chk (.*);

// File: tb/fifo_ring_ptr_test.sv
`timescale 1ns/1ps
module fifo_ring_ptr_test;
  localparam int SLOTS = 16;
  localparam int IDXW  = $clog2(SLOTS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [IDXW-1:0] cfgBottom = '0, cfgTop = '0, cfgSelect = '0, sentIdx = '0;
  logic rxIntEn = 1'b0, ovfIntEn = 1'b0, txIntEn = 1'b0;
  logic frameStored = 1'b0, frameSent = 1'b0, lostClr = 1'b0;
  logic [1:0] causeClr = '0;
  logic [IDXW-1:0] curIdx;
  logic rxIrq, txIrq, causeRx, causeOvf, lostMsg;
  logic [SLOTS-1:0] newDataVec;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fifo_ring_ptr #(.SLOTS(SLOTS)) uut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input int b, input int t, input int s);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgBottom = IDXW'(b); cfgTop = IDXW'(t); cfgSelect = IDXW'(s);
    @(negedge clk);
    cfgWrEn = 1'b0;
    check("R6 pointer reload", curIdx, b);
  endtask

  task automatic storeFrame();
    @(negedge clk); frameStored = 1'b1;
    @(negedge clk); frameStored = 1'b0;
    @(negedge clk);
  endtask

  task automatic clearCauses();
    @(negedge clk); causeClr = 2'b11;
    @(negedge clk); causeClr = 2'b00;
    check("R5 causeRx cleared", causeRx, 0);
    check("R5 causeOvf cleared", causeOvf, 0);
  endtask

  task automatic testReset();
    check("R1 pointer", curIdx, 0);
    check("R1 rxIrq", rxIrq, 0);
    check("R1 txIrq", txIrq, 0);
    check("R1 lost", lostMsg, 0);
    check("R1 causes", {causeRx, causeOvf}, 0);
    check("R1 newData", int'(newDataVec), 0);
  endtask

  task automatic testRxWrap();
    rxIntEn = 1'b1; ovfIntEn = 1'b0;
    storeFrame();
    check("R2 advance 4->5", curIdx, 5);
    check("R2 newData slot4", newDataVec[4], 1);
    check("R4 rx pulse", rxIrq, 1);
    check("R5 causeRx", causeRx, 1);
    check("R5 causeOvf idle", causeOvf, 0);
    @(negedge clk);
    check("R4 pulse ends", rxIrq, 0);
    storeFrame();
    check("R2 advance 5->6", curIdx, 6);
    check("R4 watermark masked", causeOvf, 0);
    storeFrame();
    check("R2 wrap top->bottom", curIdx, 4);
    check("R7 no lost yet", lostMsg, 0);
    clearCauses();
  endtask

  task automatic testWatermark();
    rxIntEn = 1'b0; ovfIntEn = 1'b1;
    storeFrame();  // slot4 still holds unread data
    check("R7 lost set", lostMsg, 1);
    check("R7 lost raises no request", rxIrq, 0);
    check("R4 no hit at 5", curIdx, 5);
    storeFrame();
    check("R4 watermark pulse", rxIrq, 1);
    check("R5 causeOvf", causeOvf, 1);
    check("R5 causeRx idle", causeRx, 0);
    @(negedge clk); lostClr = 1'b1;
    @(negedge clk); lostClr = 1'b0;
    check("R7 lost cleared", lostMsg, 0);
    clearCauses();
    ovfIntEn = 1'b0;
    storeFrame();
    check("R4 no request when disabled", rxIrq, 0);
    check("R4 pointer wraps", curIdx, 4);
  endtask

  task automatic testSend();
    @(negedge clk); txIntEn = 1'b1; frameSent = 1'b1; sentIdx = 4;
    @(negedge clk); frameSent = 1'b0;
    check("R8 tx pulse", txIrq, 1);
    check("R8 slot4 cleared", newDataVec[4], 0);
    @(negedge clk);
    check("R8 tx pulse ends", txIrq, 0);
    txIntEn = 1'b0; frameSent = 1'b1; sentIdx = 5;
    @(negedge clk); frameSent = 1'b0;
    check("R8 tx masked", txIrq, 0);
    check("R8 slot5 cleared", newDataVec[5], 0);
  endtask

  task automatic testBackToBack();
    // pointer at 4, slot4 empty
    @(negedge clk); frameStored = 1'b1;
    @(negedge clk);
    @(negedge clk); frameStored = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 single advance", curIdx, 5);
    check("R3 slot5 untouched", newDataVec[5], 0);
    check("R3 slot4 stored", newDataVec[4], 1);
  endtask

  task automatic testCfgCancel();
    cfgWrite(2, 9, 3);
    @(negedge clk); frameStored = 1'b1;
    @(negedge clk); frameStored = 1'b0;
    cfgWrEn = 1'b1; cfgBottom = 7; cfgTop = 9; cfgSelect = 8;
    @(negedge clk); cfgWrEn = 1'b0;
    check("R6 reload to new bottom", curIdx, 7);
    repeat (2) @(negedge clk);
    check("R6 pending advance cancelled", curIdx, 7);
    storeFrame();
    check("R6 new ring advance", curIdx, 8);
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    cfgWrite(4, 6, 6);
    testRxWrap();
    testWatermark();
    testSend();
    testBackToBack();
    testCfgCancel();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule